// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a synthesizable behavioural model of a word-organized static memory with a 17-bit word address and a 16-bit data path made of two independent 8-bit lanes. It is controlled by active-low select, write, output-enable and per-lane enable pins. In silicon these would drive a tri-state bus. Here that bus is split into a write-data input, a read-data output and one drive flag per lane: a set flag means that lane would be driven by the memory, and a clear flag means the lane is released (high-impedance).

The control pins are decoded into four modes, in priority order. Select high gives standby. Select low with write low gives write. Select low with output enable low gives read. Anything else gives selected-but-disabled. Reads are combinational from the array at the present address.

A write lasts as long as select and write are both low. The block watches that overlap on a fast sampling clock. On the first clock edge where the overlap is seen closed, it stores the address, data and lane enables captured at the last edge where the overlap was open. The number of stored words is a parameter. Address bits above those needed for the depth are ignored, so a small array can stand in for the full space.

Top module: `bytelane_sram`

## Requirements
- R1: With select low, output enable low and write high, each lane whose enable is low has its drive flag set. Its bits of the read data equal the stored word at the current address: lane 0 is bits 7:0 and is enabled by `be_n[0]`, and lane 1 is bits 15:8 and is enabled by `be_n[1]`.
- R2: With select high, both drive flags are clear whatever the other pins are, and no write takes place.
- R3: With select low and both write and output enable high, both drive flags are clear.
- R4: While select and write are both low, both drive flags are clear whatever output enable is.
- R5: A write is committed on the first clock edge at which the select-and-write overlap is sampled closed. This holds whether write rises, select rises, or both rise together. The address, data and lane enables used are those sampled at the last edge where the overlap was open.
- R6: A committed write changes bits 7:0 only if `be_n[0]` was low, and bits 15:8 only if `be_n[1]` was low. The other lane keeps its old contents.
- R7: A change of address during a read shows the new word on the read data with no clock edge needed.
- R8: With both lane enables high, no lane is driven in any mode, and a write with both enables high leaves the word unchanged.
- R9: Asserting reset discards an open write. A write overlap that closes while reset is low stores nothing.
- R10: Only the low log2(DEPTH) address bits select a word. Addresses that differ only in higher bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the pin activity |
| rst_n | input | 1 | Asynchronous active-low reset of the write tracker |
| addr | input | 17 | Word address |
| ce_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write |
| oe_n | input | 1 | Active-low output enable |
| be_n | input | 2 | Active-low lane enables, bit 0 lower lane, bit 1 upper lane |
| wdata | input | 16 | Data presented on the bus by the host |
| rdata | output | 16 | Data the memory would drive |
| lane_drv | output | 2 | Per-lane drive flag, bit 0 lower lane |

## Verification
The bench builds the block with a depth of 16 words and the full 17-bit address. With only 16 words, the whole array can be filled with known values and read back. It also means address aliasing through the ignored upper bits can be shown with a single write. Every write ending (by write, by select, or by both at once), lane masking, mid-window data and address changes, and a reset that lands inside an open window are all driven against a behavioural model that is compared on every clock.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_t;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  output sram_mode_t       mode,
  output logic [LANES-1:0] lane_drv
);
  // Priority: deselect, then write (overrides output enable), then read.
  always_comb begin
    if (ce_n)       mode = MODE_OFF;
    else if (!we_n) mode = MODE_WRITE;
    else if (!oe_n) mode = MODE_READ;
    else            mode = MODE_IDLE;
  end

  always_comb begin
    if (mode == MODE_READ) lane_drv = ~be_n;
    else                   lane_drv = '0;
  end
endmodule

// File: rtl/sram_wr_track.sv
module sram_wr_track #(
  parameter int IDX_W  = 11,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_open,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  be_n,
  output logic [LANES-1:0]  commit_lanes,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  logic              win_q, win_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [LANES-1:0]  be_q, be_d;
  logic              cap_en;
  logic              commit;

  assign cap_en = win_open;

  always_comb begin
    win_d = win_open;
    idx_d = idx_q;
    dat_d = dat_q;
    be_d  = be_q;
    if (cap_en) begin
      idx_d = idx;
      dat_d = din;
      be_d  = be_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  always_ff @(posedge clk) begin
    idx_q <= idx_d;
    dat_q <= dat_d;
    be_q  <= be_d;
  end

  assign commit       = win_q & ~win_open;
  assign commit_lanes = {LANES{commit}} & ~be_q;
  assign wr_idx       = idx_q;
  assign wr_data      = dat_q;

  assert_commit_after_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(win_open));
  assert_commit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int DEPTH  = 2048,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[g]) store[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = store[rd_idx];
  end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DEPTH  = 2048,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  lane_drv
);
  sram_mode_t        mode;
  logic              win_open;
  logic [IDX_W-1:0]  idx;
  logic [LANES-1:0]  commit_lanes;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  assign idx = addr[IDX_W-1:0];

  if (IDX_W < ADDR_W) begin : g_alias
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:IDX_W];
  end

  sram_mode_dec #(.LANES(LANES)) u_dec (
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .be_n     (be_n),
    .mode     (mode),
    .lane_drv (lane_drv)
  );

  assign win_open = (mode == MODE_WRITE);

  sram_wr_track #(.IDX_W(IDX_W), .LANES(LANES), .LANE_W(LANE_W)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_open     (win_open),
    .idx          (idx),
    .din          (wdata),
    .be_n         (be_n),
    .commit_lanes (commit_lanes),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data)
  );

  sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .wr_en   (commit_lanes),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (idx),
    .rd_data (rdata)
  );

  assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (lane_drv == '0));
  assert_disabled_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && we_n) |-> (lane_drv == '0));
  assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> (lane_drv == '0));
  assert_no_lane_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&be_n) |-> (lane_drv == '0));
  assert_commit_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_lanes != '0) |-> $past(!ce_n && !we_n));
endmodule

// File: tb/bytelane_sram_tb_top.sv
module bytelane_sram_tb_top;
  localparam int AW = 17;
  localparam int DEPTH = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, we_n, oe_n;
  logic [1:0]    be_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [1:0]    lane_drv;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bytelane_sram #(.ADDR_W(AW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .be_n(be_n), .wdata(wdata), .rdata(rdata), .lane_drv(lane_drv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [DW-1:0] mm [DEPTH];
  bit   [1:0]    kn [DEPTH];
  bit            p_open = 0;
  int            p_idx = 0;
  logic [DW-1:0] p_din = '0;
  logic [1:0]    p_be = '1;

  initial for (int i = 0; i < DEPTH; i++) kn[i] = 2'b00;

  always @(posedge clk) begin
    bit open_now;
    int ix;
    bit [1:0] exp_drv;
    string tag;
    open_now = (ce_n === 1'b0) && (we_n === 1'b0);
    if (rst_n !== 1'b1) p_open = 0;
    else begin
      if (p_open && !open_now) begin
        for (int l = 0; l < 2; l++)
          if (!p_be[l]) begin
            mm[p_idx][l*8 +: 8] = p_din[l*8 +: 8];
            kn[p_idx][l] = 1'b1;
          end
      end
      if (open_now) begin
        p_idx = int'(addr) % DEPTH;
        p_din = wdata;
        p_be  = be_n;
      end
      p_open = open_now;
    end
    #5;
    if (!finished) begin
      ix = int'(addr) % DEPTH;
      for (int l = 0; l < 2; l++)
        exp_drv[l] = !ce_n && !oe_n && we_n && !be_n[l];
      if (ce_n) tag = "R2";
      else if (!we_n) tag = "R4";
      else if (oe_n) tag = "R3";
      else if (&be_n) tag = "R8";
      else tag = "R1";
      chk(tag, 32'(lane_drv), 32'(exp_drv));
      for (int l = 0; l < 2; l++)
        if (exp_drv[l] && kn[ix][l])
          chk("R1 R5 R6 model", 32'(rdata[l*8 +: 8]), 32'(mm[ix][l*8 +: 8]));
    end
  end

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; be_n = 2'b11;
  endtask

  // end_mode: 0 write rises, 1 select rises, 2 both rise
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [1:0] be, input int end_mode);
    @(negedge clk);
    addr = a; wdata = d; be_n = be; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    if (end_mode == 0) we_n = 1'b1;
    else if (end_mode == 1) ce_n = 1'b1;
    else begin we_n = 1'b1; ce_n = 1'b1; end
    @(negedge clk);
    idle();
  endtask

  task automatic rd_full(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    addr = a; be_n = 2'b00; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #2;
    chk(req, 32'(lane_drv), 32'h3);
    chk(req, 32'(rdata), 32'(exp));
  endtask

  function automatic logic [DW-1:0] fillv(input int k);
    return 16'hA000 + 16'(k) * 16'h0111;
  endfunction

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle(); addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset state", 32'(lane_drv), 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < DEPTH; k++) wr(AW'(k), fillv(k), 2'b00, 0);
    for (int k = 0; k < DEPTH; k++) rd_full("R1", AW'(k), fillv(k));

    // R1 partial: lower lane only
    @(negedge clk);
    addr = 1; be_n = 2'b10; ce_n = 0; oe_n = 0; we_n = 1;
    #2;
    chk("R1 low lane drive", 32'(lane_drv), 32'h1);
    chk("R1 low lane data", 32'(rdata[7:0]), 32'h11);
    // R8: no lane enabled during read
    @(negedge clk);
    be_n = 2'b11;
    #2;
    chk("R8 read no lanes", 32'(lane_drv), 32'h0);
    idle();

    // R6 masking
    wr(5, 16'h1234, 2'b10, 0);
    rd_full("R6 low only", 5, 16'hA534);
    wr(6, 16'h5678, 2'b01, 0);
    rd_full("R6 high only", 6, 16'h5666);
    wr(7, 16'hFFFF, 2'b11, 0);
    rd_full("R8 write no lanes", 7, fillv(7));

    // R5 endings
    wr(8, 16'hBEEF, 2'b00, 1);
    rd_full("R5 select ends", 8, 16'hBEEF);
    wr(9, 16'hCAFE, 2'b00, 2);
    rd_full("R5 both end", 9, 16'hCAFE);

    // R5 last sampled address and data win
    @(negedge clk);
    addr = 10; wdata = 16'h1111; be_n = 2'b00; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    addr = 11; wdata = 16'h2222;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    idle();
    rd_full("R5 last sample", 11, 16'h2222);
    rd_full("R5 earlier addr untouched", 10, fillv(10));

    // R4 output enable ignored in write
    @(negedge clk);
    addr = 12; wdata = 16'h0C0C; be_n = 2'b00; ce_n = 0; we_n = 0; oe_n = 0;
    #2;
    chk("R4 no drive", 32'(lane_drv), 32'h0);
    @(negedge clk);
    we_n = 1; oe_n = 1;
    @(negedge clk);
    idle();
    rd_full("R4 write done", 12, 16'h0C0C);

    // R3 outputs disabled
    @(negedge clk);
    addr = 2; be_n = 2'b00; ce_n = 0; oe_n = 1; we_n = 1;
    #2;
    chk("R3 disabled", 32'(lane_drv), 32'h0);

    // R2 deselected with others active
    @(negedge clk);
    addr = 13; wdata = 16'h0000; ce_n = 1; oe_n = 0; we_n = 0; be_n = 2'b00;
    #2;
    chk("R2 deselect", 32'(lane_drv), 32'h0);
    @(negedge clk);
    @(negedge clk);
    idle();
    rd_full("R2 no write", 13, fillv(13));

    // R7 combinational address change
    rd_full("R7 first", 1, fillv(1));
    #3;
    addr = 2;
    #1;
    chk("R7 new word", 32'(rdata), 32'(fillv(2)));
    idle();

    // R10 aliasing
    wr(17'h10003, 16'h3333, 2'b00, 0);
    rd_full("R10 alias low", 3, 16'h3333);
    rd_full("R10 alias high", 17'h1FFF3, 16'h3333);

    // R9 reset drops open window
    @(negedge clk);
    addr = 4; wdata = 16'h4444; be_n = 2'b00; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    ce_n = 1; we_n = 1;
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    rd_full("R9 reset drop", 4, fillv(4));

    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule